// File: doc/BRIEF.md
# Addressed Receive Cell-Available Responder

This block sits on the physical-layer side of a receive bus that several ports share with one cell-layer master. It keeps a programmable port address and, on every rising edge of the receive clock, captures the shared address bus and the active-low enable. When the captured address equals its own, the block drives the shared cell-available line during the next clock cycle. The line goes high when the receive FIFO reports at least one complete cell waiting to be read, and low otherwise. In every other cycle the block releases the line by dropping its output-enable, so other ports can answer their own polls.

The master uses the level of the enable at the moment the address arrives to say what it wants. An enable that is already asserted (low) makes the access a pure availability poll, and no transfer may start. An enable that is deasserted (high) marks a selection. The block reports a selection as a one-cycle flag to the transfer logic and takes no further action on it. The FIFO supplies a count of complete cells, each cell being 53 bytes. A nonzero count means a cell is waiting.

Top module: `rx_clav_responder`

## Requirements
- R1: After reset the port address is 0x00, and `clav_oe`, `clav_out` and `select_hit` are all low.
- R2: When `bus_addr` sampled at a rising edge equals the port address, `clav_oe` is high for exactly the clock cycle that follows that edge.
- R3: In a cycle where `clav_oe` is high, `clav_out` is 1 if `cell_cnt` sampled at the same edge as the address was nonzero, and 0 if it was zero.
- R4: When the sampled address differs from the port address, `clav_oe` and `clav_out` are low in the following cycle.
- R5: `clav_out` is never high while `clav_oe` is low.
- R6: A write (`cfg_we` high at an edge) loads `cfg_wdata` into the port address. The comparison made at that same edge still uses the old address, and the new address is used from the next edge on.
- R7: A match with `bus_enb_n` high (deasserted) at the sampling edge raises `select_hit` for exactly the following cycle.
- R8: A match with `bus_enb_n` low (already asserted) at the sampling edge is a poll. `select_hit` stays low, while `clav_oe` and `clav_out` still respond as in R2 and R3.
- R9: Matches on consecutive edges keep `clav_oe` high without a gap. Each cycle's `clav_out` follows the count sampled at its own edge.
- R10: Every bit of the address takes part in the comparison. A port address of 0x1F answers only to 0x1F, and not to an address that differs in a single bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock; all sampling on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Port address register write strobe |
| cfg_wdata | input | 5 | New port address |
| bus_addr | input | 5 | Shared receive address bus |
| bus_enb_n | input | 1 | Shared active-low read enable |
| cell_cnt | input | 8 | Number of complete cells held in the receive FIFO |
| clav_out | output | 1 | Cell-available value for the shared line |
| clav_oe | output | 1 | Output-enable for the shared cell-available driver |
| select_hit | output | 1 | One-cycle flag: own address seen with enable deasserted |

## Verification
The assertions assume that `cell_cnt`, `bus_addr` and `bus_enb_n` are stable around each rising edge. They also assume that reset is applied with `cfg_we` held low, so the only path that changes the port address is the write strobe. The stimulus changes every input only on the falling edge of the clock and holds `cfg_we` low throughout reset. It reads the outputs on the following falling edge, half a cycle after the edge that produced them. Counts are drawn from zero, one and larger values, so the nonzero test on the count is exercised with many bit patterns and not only with the lowest bit.

// File: rtl/rx_clav_pkg.sv
package rx_clav_pkg;

   // Decoded outcome of one address sample
   typedef struct packed {
      logic hit;      // sampled address equals the port address
      logic poll;     // hit with the enable already asserted
      logic select;   // hit with the enable deasserted
   } rx_match_t;

   localparam int unsigned CELL_BYTES = 53;

   // Comparator variants picked by the CMP_STYLE parameter
   localparam int unsigned CMP_DIRECT  = 0;
   localparam int unsigned CMP_BITWISE = 1;

endpackage

// File: rtl/rx_port_addr_reg.sv
module rx_port_addr_reg #(
   parameter int unsigned       ADDR_W     = 5,
   parameter logic [ADDR_W-1:0] RESET_ADDR = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_data,
   output logic [ADDR_W-1:0] port_addr
);

   initial begin
      if (ADDR_W < 1 || ADDR_W > 8)
         $error("rx_port_addr_reg: ADDR_W must be 1..8");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         port_addr <= RESET_ADDR;
      else if (wr_en)
         port_addr <= wr_data;
   end

   // R6
   addr_write_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(wr_en)) |-> (port_addr == $past(wr_data)));

   // R6
   addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(wr_en)) |-> $stable(port_addr));

endmodule

// File: rtl/rx_addr_match.sv
module rx_addr_match
   import rx_clav_pkg::*;
#(
   parameter int unsigned ADDR_W    = 5,
   parameter int unsigned CMP_STYLE = CMP_BITWISE
) (
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [ADDR_W-1:0] port_addr,
   input  logic              bus_enb_n,
   output rx_match_t         result
);

   logic hit;

   initial begin
      if (CMP_STYLE != CMP_DIRECT && CMP_STYLE != CMP_BITWISE)
         $error("rx_addr_match: unknown CMP_STYLE");
   end

   generate
      if (CMP_STYLE == CMP_BITWISE) begin : g_bitwise
         logic [ADDR_W-1:0] bit_eq;
         for (genvar b = 0; b < ADDR_W; b++) begin : g_bit
            assign bit_eq[b] = ~(bus_addr[b] ^ port_addr[b]);
         end
         assign hit = &bit_eq;
      end else begin : g_direct
         assign hit = (bus_addr == port_addr);
      end
   endgenerate

   always_comb begin
      result.hit    = hit;
      result.poll   = hit & ~bus_enb_n;
      result.select = hit &  bus_enb_n;
   end

endmodule

// File: rtl/rx_clav_drive.sv
module rx_clav_drive
   import rx_clav_pkg::*;
#(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  rx_match_t        match,
   input  logic [CNT_W-1:0] cell_cnt,
   output logic             clav_out,
   output logic             clav_oe,
   output logic             select_hit
);

   logic cells_waiting;

   initial begin
      if (CNT_W < 1 || CNT_W > 32)
         $error("rx_clav_drive: CNT_W must be 1..32");
   end

   generate
      if (CNT_W == 1) begin : g_single
         assign cells_waiting = cell_cnt[0];
      end else begin : g_reduce
         assign cells_waiting = |cell_cnt;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         clav_oe    <= 1'b0;
         clav_out   <= 1'b0;
         select_hit <= 1'b0;
      end else begin
         clav_oe    <= match.hit;
         clav_out   <= match.hit & cells_waiting;
         select_hit <= match.select;
      end
   end

   // R5
   clav_needs_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clav_out |-> clav_oe);

   // R3
   clav_from_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clav_oe && $past(rst_n)) |-> (clav_out == ($past(cell_cnt) != '0)));

   // R8
   poll_no_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(match.poll)) |-> !select_hit);

endmodule

// File: rtl/rx_clav_responder.sv
module rx_clav_responder
   import rx_clav_pkg::*;
#(
   parameter int unsigned       ADDR_W     = 5,
   parameter int unsigned       CNT_W      = 8,
   parameter int unsigned       CMP_STYLE  = CMP_BITWISE,
   parameter logic [ADDR_W-1:0] RESET_ADDR = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [ADDR_W-1:0] cfg_wdata,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_enb_n,
   input  logic [CNT_W-1:0]  cell_cnt,
   output logic              clav_out,
   output logic              clav_oe,
   output logic              select_hit
);

   logic [ADDR_W-1:0] port_addr;
   rx_match_t         match;

   rx_port_addr_reg #(
      .ADDR_W     (ADDR_W),
      .RESET_ADDR (RESET_ADDR)
   ) u_addr_reg (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (cfg_we),
      .wr_data   (cfg_wdata),
      .port_addr (port_addr)
   );

   rx_addr_match #(
      .ADDR_W    (ADDR_W),
      .CMP_STYLE (CMP_STYLE)
   ) u_match (
      .bus_addr  (bus_addr),
      .port_addr (port_addr),
      .bus_enb_n (bus_enb_n),
      .result    (match)
   );

   rx_clav_drive #(
      .CNT_W (CNT_W)
   ) u_drive (
      .clk        (clk),
      .rst_n      (rst_n),
      .match      (match),
      .cell_cnt   (cell_cnt),
      .clav_out   (clav_out),
      .clav_oe    (clav_oe),
      .select_hit (select_hit)
   );

   // R2
   oe_after_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(bus_addr == port_addr)) |-> clav_oe);

   // R4
   oe_idle_on_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(bus_addr != port_addr)) |-> (!clav_oe && !clav_out));

   // R7
   select_needs_idle_enb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      select_hit |-> ($past(bus_enb_n) && clav_oe));

endmodule

// File: tb/sim_rx_clav_responder.sv
`timescale 1ns/1ps
module sim_rx_clav_responder;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_we = 1'b0;
   logic [4:0] cfg_wdata = '0;
   logic [4:0] bus_addr = 5'h1E;
   logic       bus_enb_n = 1'b1;
   logic [7:0] cell_cnt = '0;
   logic       clav_out, clav_oe, select_hit;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;   // 200 MHz

   rx_clav_responder u0 (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
      .bus_addr(bus_addr), .bus_enb_n(bus_enb_n), .cell_cnt(cell_cnt),
      .clav_out(clav_out), .clav_oe(clav_oe), .select_hit(select_hit)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // One falling edge: inputs set before it become sampled at the next rising edge
   task automatic step();
      @(negedge clk);
   endtask

   task automatic write_addr(input logic [4:0] a);
      cfg_we = 1'b1; cfg_wdata = a;
      step();
      cfg_we = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1 oe", {7'd0, clav_oe}, 8'd0);
      chk("R1 clav", {7'd0, clav_out}, 8'd0);
      chk("R1 sel", {7'd0, select_hit}, 8'd0);
      // port address 0x00 after reset: addressing 0x00 answers
      bus_addr = 5'h00; bus_enb_n = 1'b0; cell_cnt = 8'd1;
      step();
      chk("R1 addr0 oe", {7'd0, clav_oe}, 8'd1);
      bus_addr = 5'h1E;
      step();
   endtask

   task automatic t_basic_poll();
      write_addr(5'h03);
      bus_enb_n = 1'b0; cell_cnt = 8'd2; bus_addr = 5'h03;
      step();
      chk("R2 oe", {7'd0, clav_oe}, 8'd1);
      chk("R3 clav cnt2", {7'd0, clav_out}, 8'd1);
      bus_addr = 5'h01;
      step();
      chk("R2 single cycle oe", {7'd0, clav_oe}, 8'd0);
      chk("R4 miss clav", {7'd0, clav_out}, 8'd0);
      cell_cnt = 8'd0; bus_addr = 5'h03;
      step();
      chk("R3 oe empty", {7'd0, clav_oe}, 8'd1);
      chk("R3 clav empty", {7'd0, clav_out}, 8'd0);
      bus_addr = 5'h1E;
      step();
   endtask

   task automatic t_nomatch();
      cell_cnt = 8'd9;
      for (int a = 0; a < 32; a++) begin
         if (a != 3) begin
            bus_addr = a[4:0];
            step();
            chk("R4 other addr oe", {7'd0, clav_oe}, 8'd0);
            chk("R5 clav without oe", {7'd0, clav_out}, 8'd0);
         end
      end
   endtask

   task automatic t_write_timing();
      cell_cnt = 8'd1; bus_enb_n = 1'b0;
      cfg_we = 1'b1; cfg_wdata = 5'h05; bus_addr = 5'h05;
      step();
      cfg_we = 1'b0;
      chk("R6 old addr at write edge", {7'd0, clav_oe}, 8'd0);
      step();
      chk("R6 new addr next edge", {7'd0, clav_oe}, 8'd1);
      bus_addr = 5'h03;
      step();
      chk("R6 old addr dropped", {7'd0, clav_oe}, 8'd0);
      bus_addr = 5'h1E;
      step();
   endtask

   task automatic t_select();
      cell_cnt = 8'd4; bus_enb_n = 1'b1; bus_addr = 5'h05;
      step();
      chk("R7 select flag", {7'd0, select_hit}, 8'd1);
      chk("R7 oe", {7'd0, clav_oe}, 8'd1);
      bus_addr = 5'h1E;
      step();
      chk("R7 select one cycle", {7'd0, select_hit}, 8'd0);
      bus_addr = 5'h06;
      step();
      chk("R7 no select on miss", {7'd0, select_hit}, 8'd0);
   endtask

   task automatic t_poll_only();
      cell_cnt = 8'd1; bus_enb_n = 1'b0; bus_addr = 5'h05;
      step();
      chk("R8 poll no select", {7'd0, select_hit}, 8'd0);
      chk("R8 poll oe", {7'd0, clav_oe}, 8'd1);
      chk("R8 poll clav", {7'd0, clav_out}, 8'd1);
      bus_addr = 5'h1E;
      step();
   endtask

   task automatic t_back2back();
      bus_enb_n = 1'b0; bus_addr = 5'h05; cell_cnt = 8'd128;
      step();
      chk("R9 b2b oe 1", {7'd0, clav_oe}, 8'd1);
      chk("R9 b2b clav 1", {7'd0, clav_out}, 8'd1);
      cell_cnt = 8'd0;
      step();
      chk("R9 b2b oe 2", {7'd0, clav_oe}, 8'd1);
      chk("R9 b2b clav 2", {7'd0, clav_out}, 8'd0);
      cell_cnt = 8'd16;
      step();
      chk("R9 b2b oe 3", {7'd0, clav_oe}, 8'd1);
      chk("R9 b2b clav 3", {7'd0, clav_out}, 8'd1);
      bus_addr = 5'h1E;
      step();
   endtask

   task automatic t_high_addr();
      write_addr(5'h1F);
      cell_cnt = 8'd1; bus_enb_n = 1'b0;
      bus_addr = 5'h1F;
      step();
      chk("R10 0x1F match", {7'd0, clav_oe}, 8'd1);
      for (int b = 0; b < 5; b++) begin
         bus_addr = 5'h1F ^ (5'h01 << b);
         step();
         chk("R10 single bit off", {7'd0, clav_oe}, 8'd0);
      end
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      step();
      t_reset();
      t_basic_poll();
      t_nomatch();
      t_write_timing();
      t_select();
      t_poll_only();
      t_back2back();
      t_high_addr();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule